// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits beside the configuration registers of a PCI-to-PCI style bridge. It turns the packed base and limit fields of the three forwarding windows into full-width address bounds. The three windows are I/O, non-prefetchable memory and prefetchable memory. Each field keeps only its upper bits as address. Its low nibble carries a type code. For the I/O and prefetchable windows, that type code can switch in a separate upper-extension register. Limits are padded with ones down to the window granularity, so a limit always names the last byte of its last block.

A request brings an address and a space type. The decoder picks the window that belongs to that space and compares the address against that window's bounds. One clock later it reports whether the transaction should be passed downstream. The bounds themselves are combinational outputs, so neighbouring logic can show them or reuse them without waiting a cycle.

Top module: `bridge_window_decoder`

## Requirements
- R1: `io_lo` holds `io_base_reg[7:4]` in bits 15:12, with bits 11:0 zero. Bits 31:16 equal `io_base_ext` when `io_base_reg[0]` is 1 (32-bit I/O), and are zero otherwise. Bits 3:1 of the register have no effect.
- R2: `io_hi` is built from `io_limit_reg` and `io_limit_ext` in the same way as R1, using the limit register's own bit 0, and then has bits 11:0 forced to ones.
- R3: `mem_lo` holds `mem_base_reg[15:4]` in bits 31:20, with all lower bits zero. Bits 3:0 of the register have no effect.
- R4: `mem_hi` holds `mem_limit_reg[15:4]` in bits 31:20, with bits 19:0 all ones.
- R5: `pf_lo` holds `pf_base_reg[15:4]` in bits 31:20, with bits 19:0 zero. Bits 63:32 equal `pf_base_ext` when `pf_base_reg[0]` is 1 (64-bit), and are zero otherwise.
- R6: `pf_hi` is built from `pf_limit_reg` and `pf_limit_ext` in the same way as R5, and then has bits 19:0 forced to ones.
- R7: When `req_is_io` is 1, the I/O window is used, whatever `req_is_pref` is. Otherwise `req_is_pref` = 1 selects the prefetchable window and `req_is_pref` = 0 selects the non-prefetchable memory window.
- R8: A valid request forwards exactly when lo <= `req_addr` <= hi for the selected window, compared unsigned at 64 bits, with 32-bit bounds zero-extended.
- R9: A window whose base is above its limit never forwards any address.
- R10: `rsp_valid` equals `req_valid` from the previous clock. `rsp_fwd` is 0 whenever `rsp_valid` is 0.
- R11: While `rst_n` is low at a rising edge, `rsp_valid` and `rsp_fwd` are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_base_reg | input | 8 | Packed I/O base field, type code in bits 3:0 |
| io_limit_reg | input | 8 | Packed I/O limit field, type code in bits 3:0 |
| io_base_ext | input | 16 | Upper 16 bits of the I/O base |
| io_limit_ext | input | 16 | Upper 16 bits of the I/O limit |
| mem_base_reg | input | 16 | Packed memory base field |
| mem_limit_reg | input | 16 | Packed memory limit field |
| pf_base_reg | input | 16 | Packed prefetchable base field, type code in bits 3:0 |
| pf_limit_reg | input | 16 | Packed prefetchable limit field, type code in bits 3:0 |
| pf_base_ext | input | 32 | Upper 32 bits of the prefetchable base |
| pf_limit_ext | input | 32 | Upper 32 bits of the prefetchable limit |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | Request targets I/O space |
| req_is_pref | input | 1 | Memory request is prefetchable |
| io_lo | output | 32 | Expanded I/O base |
| io_hi | output | 32 | Expanded I/O limit |
| mem_lo | output | 32 | Expanded memory base |
| mem_hi | output | 32 | Expanded memory limit |
| pf_lo | output | 64 | Expanded prefetchable base |
| pf_hi | output | 64 | Expanded prefetchable limit |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_fwd | output | 1 | Forward decision for the request |

## Verification
The hardest cases to reach are the edges of a window. These are the address one below the base and the address one above the padded limit. In the prefetchable window, the upper extension moves both edges above 4 GB. Reaching them takes an address that is built from the same field and extension values the decoder receives. The stimulus computes each window's bounds arithmetically and then probes the base, the limit and their neighbours for every window, in both enabled and inverted (disabled) settings. Before that, the field expansion is swept over every I/O byte and over a dense stride of memory words, with both type codes and with varied extension values.

// File: rtl/bwd_pkg.sv
// Shared types and constants for the bridge window decoder.
// Assumes a 64-bit transaction address space.
package bwd_pkg;
    localparam int ADDR_W = 64;
    localparam int TYPE_W = 4;   // low type/reserved nibble of every field
    localparam int NUM_WIN = 3;

    typedef enum logic [1:0] {
        WIN_IO  = 2'd0,
        WIN_MEM = 2'd1,
        WIN_PF  = 2'd2
    } win_sel_e;
endpackage

// File: rtl/bwd_field_expand.sv
// Expands one packed base or limit field into a full-width bound.
// The field's upper bits land at bit GRAN upwards. When HAS_EXT is set and
// the field's type bit 0 is 1, the extension fills the top EXT_W bits.
// PAD_ONES forces the bits below GRAN to ones (used for limits).
// Assumes GRAN + FIELD_W <= OUT_W - EXT_W when HAS_EXT is set.
module bwd_field_expand #(
    parameter int REG_W    = 8,
    parameter int SHIFT    = 8,
    parameter int EXT_W    = 16,
    parameter int OUT_W    = 32,
    parameter bit HAS_EXT  = 1'b1,
    parameter bit PAD_ONES = 1'b0
) (
    input  logic [REG_W-1:0] reg_val,
    input  logic [EXT_W-1:0] ext_val,
    output logic [OUT_W-1:0] bound
);
    import bwd_pkg::*;

    localparam int FIELD_W = REG_W - TYPE_W;
    localparam int GRAN    = SHIFT + TYPE_W;

    logic [EXT_W-1:0] ext_part;
    logic             unused_type_bits;

    assign unused_type_bits = ^reg_val[TYPE_W-1:1];

    // Select the extension, or zero when the variant has none.
    generate
        if (HAS_EXT) begin : g_ext
            assign ext_part = reg_val[0] ? ext_val : '0;
        end else begin : g_noext
            logic unused_ext;
            assign unused_ext = ^ext_val;
            assign ext_part   = '0;
        end
    endgenerate

    // Place field, extension and granularity padding.
    always_comb begin
        bound = '0;
        bound[GRAN +: FIELD_W] = reg_val[REG_W-1:TYPE_W];
        if (HAS_EXT) begin
            bound[OUT_W-1 -: EXT_W] = ext_part;
        end
        if (PAD_ONES) begin
            bound[GRAN-1:0] = '1;
        end
    end
endmodule

// File: rtl/bwd_window_bounds.sv
// Builds the base and limit of one window from its packed fields.
// Assumes base and limit use the same layout. Only the limit is padded.
module bwd_window_bounds #(
    parameter int REG_W   = 8,
    parameter int SHIFT   = 8,
    parameter int EXT_W   = 16,
    parameter int OUT_W   = 32,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic [REG_W-1:0] base_reg,
    input  logic [REG_W-1:0] limit_reg,
    input  logic [EXT_W-1:0] base_ext,
    input  logic [EXT_W-1:0] limit_ext,
    output logic [OUT_W-1:0] lo,
    output logic [OUT_W-1:0] hi
);
    // Base side: aligned, never padded.
    bwd_field_expand #(
        .REG_W(REG_W), .SHIFT(SHIFT), .EXT_W(EXT_W), .OUT_W(OUT_W),
        .HAS_EXT(HAS_EXT), .PAD_ONES(1'b0)
    ) u_base (
        .reg_val(base_reg), .ext_val(base_ext), .bound(lo)
    );

    // Limit side: padded to the last byte of its block.
    bwd_field_expand #(
        .REG_W(REG_W), .SHIFT(SHIFT), .EXT_W(EXT_W), .OUT_W(OUT_W),
        .HAS_EXT(HAS_EXT), .PAD_ONES(1'b1)
    ) u_limit (
        .reg_val(limit_reg), .ext_val(limit_ext), .bound(hi)
    );
endmodule

// File: rtl/bwd_range_match.sv
// Unsigned inclusive range test. An inverted range (lo > hi) never matches.
module bwd_range_match #(
    parameter int W = 64
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] addr,
    output logic         hit
);
    // Both comparators must agree; an inverted range cannot satisfy both.
    assign hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bridge_window_decoder.sv
// Bridge address window decoder: expands the three forwarding windows and
// reports, one clock after each request, whether its address falls in the
// window of its space. Assumes register fields are stable while a request
// is in flight. Reset is synchronous, active low.
module bridge_window_decoder #(
    parameter int IO_REG_W  = 8,
    parameter int IO_SHIFT  = 8,
    parameter int IO_EXT_W  = 16,
    parameter int IO_W      = 32,
    parameter int MEM_REG_W = 16,
    parameter int MEM_SHIFT = 16,
    parameter int MEM_W     = 32,
    parameter int PF_EXT_W  = 32,
    parameter int PF_W      = 64,
    parameter int ADDR_W    = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IO_REG_W-1:0]  io_base_reg,
    input  logic [IO_REG_W-1:0]  io_limit_reg,
    input  logic [IO_EXT_W-1:0]  io_base_ext,
    input  logic [IO_EXT_W-1:0]  io_limit_ext,
    input  logic [MEM_REG_W-1:0] mem_base_reg,
    input  logic [MEM_REG_W-1:0] mem_limit_reg,
    input  logic [MEM_REG_W-1:0] pf_base_reg,
    input  logic [MEM_REG_W-1:0] pf_limit_reg,
    input  logic [PF_EXT_W-1:0]  pf_base_ext,
    input  logic [PF_EXT_W-1:0]  pf_limit_ext,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_is_io,
    input  logic                 req_is_pref,
    output logic [IO_W-1:0]      io_lo,
    output logic [IO_W-1:0]      io_hi,
    output logic [MEM_W-1:0]     mem_lo,
    output logic [MEM_W-1:0]     mem_hi,
    output logic [PF_W-1:0]      pf_lo,
    output logic [PF_W-1:0]      pf_hi,
    output logic                 rsp_valid,
    output logic                 rsp_fwd
);
    import bwd_pkg::*;

    logic [ADDR_W-1:0] win_lo  [NUM_WIN];
    logic [ADDR_W-1:0] win_hi  [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    win_sel_e           sel;
    logic               hit_sel;

    // I/O window: byte field with optional 16-bit upper half.
    bwd_window_bounds #(
        .REG_W(IO_REG_W), .SHIFT(IO_SHIFT), .EXT_W(IO_EXT_W),
        .OUT_W(IO_W), .HAS_EXT(1'b1)
    ) u_io (
        .base_reg(io_base_reg), .limit_reg(io_limit_reg),
        .base_ext(io_base_ext), .limit_ext(io_limit_ext),
        .lo(io_lo), .hi(io_hi)
    );

    // Non-prefetchable memory window: 32-bit only.
    bwd_window_bounds #(
        .REG_W(MEM_REG_W), .SHIFT(MEM_SHIFT), .EXT_W(1),
        .OUT_W(MEM_W), .HAS_EXT(1'b0)
    ) u_mem (
        .base_reg(mem_base_reg), .limit_reg(mem_limit_reg),
        .base_ext(1'b0), .limit_ext(1'b0),
        .lo(mem_lo), .hi(mem_hi)
    );

    // Prefetchable memory window: optional 32-bit upper half.
    bwd_window_bounds #(
        .REG_W(MEM_REG_W), .SHIFT(MEM_SHIFT), .EXT_W(PF_EXT_W),
        .OUT_W(PF_W), .HAS_EXT(1'b1)
    ) u_pf (
        .base_reg(pf_base_reg), .limit_reg(pf_limit_reg),
        .base_ext(pf_base_ext), .limit_ext(pf_limit_ext),
        .lo(pf_lo), .hi(pf_hi)
    );

    // Zero-extend every window to the address width.
    always_comb begin
        win_lo[WIN_IO]  = ADDR_W'(io_lo);
        win_hi[WIN_IO]  = ADDR_W'(io_hi);
        win_lo[WIN_MEM] = ADDR_W'(mem_lo);
        win_hi[WIN_MEM] = ADDR_W'(mem_hi);
        win_lo[WIN_PF]  = ADDR_W'(pf_lo);
        win_hi[WIN_PF]  = ADDR_W'(pf_hi);
    end

    // One comparator pair per window.
    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
            bwd_range_match #(.W(ADDR_W)) u_match (
                .lo(win_lo[w]), .hi(win_hi[w]),
                .addr(req_addr), .hit(win_hit[w])
            );
        end
    endgenerate

    // Space type picks the window; I/O takes precedence.
    always_comb begin
        if (req_is_io)        sel = WIN_IO;
        else if (req_is_pref) sel = WIN_PF;
        else                  sel = WIN_MEM;
        hit_sel = win_hit[sel];
    end

    // Register the decision alongside its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fwd   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fwd   <= req_valid & hit_sel;
        end
    end
endmodule

// File: rtl/bwd_checker.sv
// Temporal checks for the bridge window decoder, bound to the top module.
module bwd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_addr,
    input logic        req_is_io,
    input logic        req_is_pref,
    input logic [31:0] io_lo,
    input logic [31:0] io_hi,
    input logic [31:0] mem_lo,
    input logic [31:0] mem_hi,
    input logic [63:0] pf_lo,
    input logic [63:0] pf_hi,
    input logic        rsp_valid,
    input logic        rsp_fwd
);
    logic armed;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    AST_RSP_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        rsp_valid == $past(req_valid)); // R10
    AST_FWD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fwd |-> rsp_valid); // R10
    AST_IO_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        io_lo[11:0] == 12'h000); // R1
    AST_IO_LIMIT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        io_hi[11:0] == 12'hFFF); // R2
    AST_MEM_LIMIT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hi[19:0] == 20'hFFFFF); // R4
    AST_PF_LIMIT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        pf_hi[19:0] == 20'hFFFFF); // R6
    AST_IO_INVERTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(req_valid && req_is_io && (io_lo > io_hi)) |-> !rsp_fwd); // R9
    AST_MEM_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(req_valid && !req_is_io && !req_is_pref &&
              ((req_addr < {32'h0, mem_lo}) || (req_addr > {32'h0, mem_hi}))) |-> !rsp_fwd); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_fwd)); // R11
endmodule

bind bridge_window_decoder bwd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_is_pref(req_is_pref),
    .io_lo(io_lo), .io_hi(io_hi), .mem_lo(mem_lo), .mem_hi(mem_hi),
    .pf_lo(pf_lo), .pf_hi(pf_hi), .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd)
);

// File: tb/sim_bridge_window_decoder.sv
`timescale 1ns/1ps
module sim_bridge_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_base_reg = '0, io_limit_reg = '0;
    logic [15:0] io_base_ext = '0, io_limit_ext = '0;
    logic [15:0] mem_base_reg = '0, mem_limit_reg = '0;
    logic [15:0] pf_base_reg = '0, pf_limit_reg = '0;
    logic [31:0] pf_base_ext = '0, pf_limit_ext = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_is_io = 1'b0, req_is_pref = 1'b0;
    logic [31:0] io_lo, io_hi, mem_lo, mem_hi;
    logic [63:0] pf_lo, pf_hi;
    logic        rsp_valid, rsp_fwd;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bridge_window_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
        .io_base_ext(io_base_ext), .io_limit_ext(io_limit_ext),
        .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
        .pf_base_reg(pf_base_reg), .pf_limit_reg(pf_limit_reg),
        .pf_base_ext(pf_base_ext), .pf_limit_ext(pf_limit_ext),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_is_io(req_is_io), .req_is_pref(req_is_pref),
        .io_lo(io_lo), .io_hi(io_hi), .mem_lo(mem_lo), .mem_hi(mem_hi),
        .pf_lo(pf_lo), .pf_hi(pf_hi),
        .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Arithmetic models of the window bounds.
    function automatic logic [63:0] m_io(input logic [7:0] r, input logic [15:0] e, input bit lim);
        logic [63:0] v = 64'(r / 16) * 64'd4096;
        if (r % 2 == 1) v = v + 64'(e) * 64'd65536;
        if (lim) v = v + 64'd4095;
        return v;
    endfunction

    function automatic logic [63:0] m_mem(input logic [15:0] r, input bit lim);
        logic [63:0] v = 64'(r / 16) * 64'd1048576;
        if (lim) v = v + 64'd1048575;
        return v;
    endfunction

    function automatic logic [63:0] m_pf(input logic [15:0] r, input logic [31:0] e, input bit lim);
        logic [63:0] v = m_mem(r, lim);
        if (r % 2 == 1) v = v + 64'(e) * 64'h1_0000_0000;
        return v;
    endfunction

    // Issue one request and check its registered result.
    task automatic send(input logic is_io, input logic is_pref, input logic [63:0] a,
                        input string rq, input bit force_miss);
        logic [63:0] lo, hi;
        logic exp;
        if (is_io) begin
            lo = m_io(io_base_reg, io_base_ext, 0);
            hi = m_io(io_limit_reg, io_limit_ext, 1);
        end else if (is_pref) begin
            lo = m_pf(pf_base_reg, pf_base_ext, 0);
            hi = m_pf(pf_limit_reg, pf_limit_ext, 1);
        end else begin
            lo = m_mem(mem_base_reg, 0);
            hi = m_mem(mem_limit_reg, 1);
        end
        exp = (a >= lo) && (a <= hi);
        if (force_miss) exp = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = is_io; req_is_pref = is_pref;
        @(negedge clk);
        req_valid = 1'b0;
        chk({rq, " valid"}, 64'(rsp_valid), 64'd1);
        chk({rq, " fwd"}, 64'(rsp_fwd), 64'(exp));
    endtask

    // Probe base, limit and both neighbours of the selected window.
    task automatic probe(input logic is_io, input logic is_pref, input string rq, input bit inverted);
        logic [63:0] lo, hi;
        if (is_io) begin
            lo = m_io(io_base_reg, io_base_ext, 0);
            hi = m_io(io_limit_reg, io_limit_ext, 1);
        end else if (is_pref) begin
            lo = m_pf(pf_base_reg, pf_base_ext, 0);
            hi = m_pf(pf_limit_reg, pf_limit_ext, 1);
        end else begin
            lo = m_mem(mem_base_reg, 0);
            hi = m_mem(mem_limit_reg, 1);
        end
        send(is_io, is_pref, lo - 1, rq, inverted);
        send(is_io, is_pref, lo, rq, inverted);
        send(is_io, is_pref, lo + 1, rq, inverted);
        send(is_io, is_pref, hi - 1, rq, inverted);
        send(is_io, is_pref, hi, rq, inverted);
        send(is_io, is_pref, hi + 1, rq, inverted);
        send(is_io, is_pref, 64'h0, rq, inverted);
        send(is_io, is_pref, '1, rq, inverted);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset holds the result low even with a request present.
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset valid", 64'(rsp_valid), 64'd0);
        chk("R11 reset fwd", 64'(rsp_fwd), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;

        // R1 R2: every I/O byte, both type codes through bit 0.
        for (int i = 0; i < 256; i++) begin
            io_base_reg = 8'(i); io_limit_reg = 8'(255 - i);
            io_base_ext = 16'(i * 16'h0101 ^ 16'hA5C3);
            io_limit_ext = 16'(i * 16'h0303 ^ 16'h1234);
            #1;
            chk("R1 io_lo", 64'(io_lo), m_io(io_base_reg, io_base_ext, 0));
            chk("R2 io_hi", 64'(io_hi), m_io(io_limit_reg, io_limit_ext, 1));
        end

        // R3 R4 R5 R6: dense stride over the 16-bit fields.
        for (int i = 0; i < 65536; i += 5) begin
            mem_base_reg = 16'(i); mem_limit_reg = 16'(i ^ 16'h5A5A);
            pf_base_reg = 16'(i ^ 16'h0001); pf_limit_reg = 16'(i * 3);
            pf_base_ext = 32'(i) * 32'h0101_0101 ^ 32'hDEAD_0000;
            pf_limit_ext = 32'(i) * 32'h0007_0003 ^ 32'h0000_BEEF;
            #1;
            chk("R3 mem_lo", 64'(mem_lo), m_mem(mem_base_reg, 0));
            chk("R4 mem_hi", 64'(mem_hi), m_mem(mem_limit_reg, 1));
            chk("R5 pf_lo", pf_lo, m_pf(pf_base_reg, pf_base_ext, 0));
            chk("R6 pf_hi", pf_hi, m_pf(pf_limit_reg, pf_limit_ext, 1));
        end

        // R8: enabled windows, edges and neighbours.
        io_base_reg = 8'h21; io_base_ext = 16'h0001;
        io_limit_reg = 8'h41; io_limit_ext = 16'h0001;
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h156E;
        pf_base_reg = 16'h0011; pf_base_ext = 32'h2;
        pf_limit_reg = 16'h0101; pf_limit_ext = 32'h2;
        probe(1'b1, 1'b0, "R8 io window", 0);
        probe(1'b0, 1'b0, "R8 mem window", 0);
        probe(1'b0, 1'b1, "R8 pf window", 0);
        // I/O with 16-bit addressing (type 0): extension ignored.
        io_base_reg = 8'h30; io_limit_reg = 8'h70;
        probe(1'b1, 1'b0, "R8 io 16-bit", 0);

        // R7: window choice by space type.
        send(1'b0, 1'b0, 64'h2_0010_0000, "R7 mem ignores pf window", 0);
        send(1'b1, 1'b1, 64'h0000_5000, "R7 io wins over pref", 0);
        send(1'b0, 1'b1, 64'h1230_0000, "R7 pf ignores mem window", 0);

        // R9: inverted windows never forward.
        io_base_reg = 8'h50; io_limit_reg = 8'h40;
        mem_base_reg = 16'h2000; mem_limit_reg = 16'h1FF0;
        pf_base_reg = 16'h0021; pf_base_ext = 32'h3;
        pf_limit_reg = 16'h0F01; pf_limit_ext = 32'h2;
        probe(1'b1, 1'b0, "R9 io inverted", 1);
        probe(1'b0, 1'b0, "R9 mem inverted", 1);
        probe(1'b0, 1'b1, "R9 pf inverted", 1);

        // R10: idle cycle after a forwarded request.
        mem_base_reg = 16'h0000; mem_limit_reg = 16'hFFF0;
        send(1'b0, 1'b0, 64'h0000_1000, "R10 hit before idle", 0);
        @(negedge clk);
        chk("R10 idle valid", 64'(rsp_valid), 64'd0);
        chk("R10 idle fwd", 64'(rsp_fwd), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule